// File: doc/BRIEF.md
# GPIO Port Register Block

This block is a memory-mapped general-purpose I/O port with 32 pins, sitting on a plain 32-bit register bus made of an address, a write strobe, write data and read data. Software decides which pins are outputs through a pair of registers: one only turns pins into outputs and the other only turns them back into inputs. Writing a 1 acts on that pin and writing a 0 leaves it as it is.

Output levels are held in two half-port registers of 16 pins each. Every write to one of them carries its own per-pin mask in the upper half of the data word, so one pin can change without a read-modify-write sequence. Pad levels pass through a two-stage synchronizer before software can read them. Toward the pads the block presents an output-value vector, an output-enable vector and takes an input vector. Pad cells, pin multiplexing and interrupt logic lie outside the block.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is asserted and after it is released, every pin is an input (`pad_oe` all 0), every output value bit is 0 (`pad_out` all 0), and `bus_rdata` is 0.
- R2: A write to offset 0x00 makes each pin whose data bit is 1 an output. Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x04 makes each pin whose data bit is 1 an input. Pins whose data bit is 0 keep their direction.
- R4: A write to offset 0x08 updates output bit i (i in 0..15) to data bit i only where data bit 16+i is 1. The other low-half bits keep their values.
- R5: A write to offset 0x0C updates output bit 16+i (i in 0..15) to data bit i only where data bit 16+i is 1. A write with bits 31:16 all zero changes nothing.
- R6: Output values can be loaded while a pin is an input. They show on `pad_out` at once, and the pin drives the loaded value on the first cycle after it becomes an output.
- R7: Reading offset 0x10 returns the pad levels after a two-flop synchronizer. A pad change made before clock edge N shows on `bus_rdata` after edge N+2.
- R8: Reading offset 0x00 or 0x04 returns the 32-bit direction vector, with 1 meaning output. Reading 0x08 or 0x0C returns that half's 16 output values in bits 15:0, and bits 31:16 read as 0.
- R9: A write takes effect on the clock edge at which `bus_wr` is high. `bus_rdata` is registered and reflects the address presented one edge earlier.
- R10: Writes to offset 0x10 and to any unmapped offset change no pin state, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin, 1 = drive |

## Verification
The bench targets the masked half-port writes. It uses a mask that clears some set bits, an all-zero mask, and a write to the upper half that must leave the lower half alone. A design that ignored the mask or used the wrong half would corrupt neighbouring pins. It checks that direction set and clear touch only the pins marked by ones, so a design that simply copied the data word would drop existing outputs. Further checks cover the exact edge on which a synchronized pad change becomes readable, which catches a missing or extra stage, and the one-edge read latency. It also loads an output value while the pin is an input and confirms that value is driven once the pin is switched, so a design that cleared the value on the direction change is caught. Finally it writes the input and unmapped offsets, which a loose address decoder would let alias onto real registers.

// File: rtl/gpio_port_pkg.sv
// Package: shared register offsets, the decoded select type and the decoder.
// Assumes byte offsets on a 32-bit bus; only exact offsets decode.
package gpio_port_pkg;

    localparam int unsigned OFF_DIR_SET = 32'h00;
    localparam int unsigned OFF_DIR_CLR = 32'h04;
    localparam int unsigned OFF_OUT_LO  = 32'h08;
    localparam int unsigned OFF_OUT_HI  = 32'h0C;
    localparam int unsigned OFF_INPUT   = 32'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR_SET,
        SEL_DIR_CLR,
        SEL_OUT_LO,
        SEL_OUT_HI,
        SEL_INPUT
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        reg_sel_e s;
        case (off)
            OFF_DIR_SET: s = SEL_DIR_SET;
            OFF_DIR_CLR: s = SEL_DIR_CLR;
            OFF_OUT_LO:  s = SEL_OUT_LO;
            OFF_OUT_HI:  s = SEL_OUT_HI;
            OFF_INPUT:   s = SEL_INPUT;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_dir_reg.sv
// Direction register: each 1 in a set write turns that pin into an output,
// and each 1 in a clear write turns it into an input. A set write and a clear
// write never coincide because they come from one decoded address.
module gpio_dir_reg #(
    parameter int PIN_N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [PIN_N-1:0] bits,
    output logic [PIN_N-1:0] dir_q
);

    // Purpose: apply the set or clear pattern, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (set_en) begin
            dir_q <= dir_q | bits;
        end else if (clr_en) begin
            dir_q <= dir_q & ~bits;
        end
    end

endmodule

// File: rtl/gpio_out_half.sv
// One half-port output register. The upper half of the write word is a
// per-pin mask and the lower half carries the new values; only pins with a
// mask bit of 1 change.
module gpio_out_half #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [HALF_W-1:0] val_q
);

    logic [HALF_W-1:0] mask;
    logic [HALF_W-1:0] newv;
    logic [HALF_W-1:0] merged;

    // Purpose: split the word and merge the masked values into the held ones.
    always_comb begin
        mask   = wdata[DATA_W-1:HALF_W];
        newv   = wdata[HALF_W-1:0];
        merged = (val_q & ~mask) | (newv & mask);
    end

    // Purpose: store the merged half on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (wr_en) begin
            val_q <= merged;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for the asynchronous pad inputs. The stage count
// is a parameter, with a minimum of two. All stages reset to zero.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Purpose: first stage samples the raw pads.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Purpose: each later stage retimes the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_rd_mux.sv
// Registered read multiplexer. It picks the addressed register and zero-extends
// each output half. Unmapped selects read as zero, with one cycle of latency.
module gpio_rd_mux
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] dir_v,
    input  logic [HALF_W-1:0] out_lo,
    input  logic [HALF_W-1:0] out_hi,
    input  logic [DATA_W-1:0] in_v,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] pick;

    // Purpose: choose the source for the addressed register.
    always_comb begin
        case (sel)
            SEL_DIR_SET, SEL_DIR_CLR: pick = dir_v;
            SEL_OUT_LO: pick = {{(DATA_W-HALF_W){1'b0}}, out_lo};
            SEL_OUT_HI: pick = {{(DATA_W-HALF_W){1'b0}}, out_hi};
            SEL_INPUT:  pick = in_v;
            default:    pick = '0;
        endcase
    end

    // Purpose: register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= pick;
    end

endmodule

// File: rtl/gpio_port_regs.sv
// Top of the GPIO port register block. It decodes the bus address, routes
// writes to the direction and output-half registers, synchronizes the pads
// and drives registered read data. The pin count equals the bus width.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe
);

    localparam int HALF_W = DATA_W / 2;
    localparam int HALVES = 2;

    reg_sel_e          sel;
    logic [DATA_W-1:0] in_sync;
    logic [HALF_W-1:0] half_q [HALVES];

    // Purpose: decode the byte offset into a register select.
    always_comb begin
        sel = decode_offset(32'(bus_addr));
    end

    gpio_dir_reg #(.PIN_N(DATA_W)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_wr && (sel == SEL_DIR_SET)),
        .clr_en (bus_wr && (sel == SEL_DIR_CLR)),
        .bits   (bus_wdata),
        .dir_q  (pad_oe)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam reg_sel_e MY_SEL = (h == 0) ? SEL_OUT_LO : SEL_OUT_HI;
        gpio_out_half #(.DATA_W(DATA_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr && (sel == MY_SEL)),
            .wdata (bus_wdata),
            .val_q (half_q[h])
        );
        assign pad_out[h*HALF_W +: HALF_W] = half_q[h];
    end

    gpio_in_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    gpio_rd_mux #(.DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .dir_v  (pad_oe),
        .out_lo (half_q[0]),
        .out_hi (half_q[1]),
        .in_v   (in_sync),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/gpio_port_regs_chk.sv
// Checker for gpio_port_regs, attached by bind. It observes only the ports
// and keeps a small counter of the edges since reset to bound lookback.
module gpio_port_regs_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pad_in,
    input logic [DATA_W-1:0] pad_out,
    input logic [DATA_W-1:0] pad_oe
);

    localparam int HALF_W = DATA_W / 2;
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(gpio_port_pkg::OFF_DIR_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(gpio_port_pkg::OFF_DIR_CLR);
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(gpio_port_pkg::OFF_OUT_LO);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(gpio_port_pkg::OFF_OUT_HI);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(gpio_port_pkg::OFF_INPUT);

    logic [1:0] age;

    // Purpose: count edges out of reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= '0;
        else if (age != 3) age <= age + 2'd1;
    end

    // R1: reset clears pin state and read data.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0) && (pad_out == '0) && (bus_rdata == '0));

    // R2: set write adds the marked pins and keeps the rest.
    p_dir_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SET) |=>
            (pad_oe == ($past(pad_oe) | $past(bus_wdata))));

    // R3: clear write removes the marked pins only.
    p_dir_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLR) |=>
            (pad_oe == ($past(pad_oe) & ~$past(bus_wdata))));

    // R4: low-half masked write.
    p_lo_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LO) |=>
            (pad_out[HALF_W-1:0] ==
                (($past(pad_out[HALF_W-1:0]) & ~$past(bus_wdata[DATA_W-1:HALF_W])) |
                 ($past(bus_wdata[HALF_W-1:0]) & $past(bus_wdata[DATA_W-1:HALF_W]))))
            && $stable(pad_out[DATA_W-1:HALF_W]));

    // R5: high-half masked write.
    p_hi_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_HI) |=>
            (pad_out[DATA_W-1:HALF_W] ==
                (($past(pad_out[DATA_W-1:HALF_W]) & ~$past(bus_wdata[DATA_W-1:HALF_W])) |
                 ($past(bus_wdata[HALF_W-1:0]) & $past(bus_wdata[DATA_W-1:HALF_W]))))
            && $stable(pad_out[HALF_W-1:0]));

    // R7: input read shows pads three edges old.
    p_input_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(bus_addr) == A_IN) |-> (bus_rdata == $past(pad_in, 3)));

    // R8: output-half reads have a zero upper half.
    p_half_read_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && ($past(bus_addr) == A_LO || $past(bus_addr) == A_HI)) |->
            (bus_rdata[DATA_W-1:HALF_W] == '0));

    // R10: without a write, pin state holds.
    p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pad_oe) && $stable(pad_out));

    // R10: writes to the input or unmapped offsets leave pins alone.
    p_ignored_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != A_SET && bus_addr != A_CLR &&
         bus_addr != A_LO && bus_addr != A_HI) |=>
            $stable(pad_oe) && $stable(pad_out));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/test_gpio_port_regs.sv
// Directed bench for gpio_port_regs: one task per scenario, each self-checked.
module test_gpio_port_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_regs i_gpio_port_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] r;
        check("R1 oe after reset", pad_oe, 32'h0);
        check("R1 out after reset", pad_out, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        bus_read(8'h00, r);
        check("R1 dir read after reset", r, 32'h0);
    endtask

    task automatic t_direction;
        logic [31:0] r;
        bus_write(8'h00, 32'h0000_00F1);
        check("R2 set first", pad_oe, 32'h0000_00F1);
        bus_write(8'h00, 32'h8000_0100);
        check("R2 set keeps others", pad_oe, 32'h8000_01F1);
        bus_write(8'h04, 32'h0000_0031);
        check("R3 clear marked only", pad_oe, 32'h8000_01C0);
        bus_read(8'h00, r);
        check("R8 dir read at set offset", r, 32'h8000_01C0);
        bus_read(8'h04, r);
        check("R8 dir read at clear offset", r, 32'h8000_01C0);
    endtask

    task automatic t_output;
        logic [31:0] r;
        bus_write(8'h08, 32'hFFFF_A5A5);
        check("R4 full-mask low write", pad_out, 32'h0000_A5A5);
        bus_write(8'h08, 32'h00F0_0F0F);
        check("R4 partial mask low", pad_out, 32'h0000_A505);
        bus_write(8'h0C, 32'h8001_FFFF);
        check("R5 high write keeps low", pad_out, 32'h8001_A505);
        bus_write(8'h0C, 32'h0000_1234);
        check("R5 zero mask no change", pad_out, 32'h8001_A505);
        bus_read(8'h08, r);
        check("R8 low half read", r, 32'h0000_A505);
        bus_read(8'h0C, r);
        check("R8 high half read", r, 32'h0000_8001);
    endtask

    task automatic t_preload;
        bus_write(8'h04, 32'hFFFF_FFFF);
        check("R3 clear all", pad_oe, 32'h0);
        bus_write(8'h08, 32'h0008_0008);
        check("R6 preload visible", pad_out, 32'h8001_A50D);
        check("R6 pin still input", pad_oe, 32'h0);
        bus_write(8'h00, 32'h0000_0008);
        check("R6 now output", pad_oe, 32'h0000_0008);
        check("R6 drives preloaded value", pad_out & pad_oe, 32'h0000_0008);
    endtask

    task automatic t_timing;
        logic [31:0] r;
        bus_read(8'h08, r);
        check("R9 low read", r, 32'h0000_A50D);
        @(negedge clk);
        bus_addr = 8'h0C;
        #1 check("R9 rdata not yet changed", bus_rdata, 32'h0000_A50D);
        @(negedge clk);
        check("R9 rdata one edge later", bus_rdata, 32'h0000_8001);
        bus_addr = 8'h00; bus_wr = 1'b1; bus_wdata = 32'h0001_0000;
        #1 check("R9 no effect before edge", pad_oe, 32'h0000_0008);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9 effect at strobe edge", pad_oe, 32'h0001_0008);
    endtask

    task automatic t_input;
        @(negedge clk);
        bus_addr = 8'h10;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(negedge clk);
        check("R7 not after 1 edge", bus_rdata, 32'h0);
        @(negedge clk);
        check("R7 not after 2 edges", bus_rdata, 32'h0);
        @(negedge clk);
        check("R7 visible after 3 edges", bus_rdata, 32'h1234_5678);
        pad_in = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        check("R7 second pattern", bus_rdata, 32'hFFFF_0000);
    endtask

    task automatic t_unmapped;
        logic [31:0] r;
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_write(8'h48, 32'hFFFF_FFFF);
        check("R10 oe unchanged", pad_oe, 32'h0001_0008);
        check("R10 out unchanged", pad_out, 32'h8001_A50D);
        bus_read(8'h14, r);
        check("R10 unmapped reads 0", r, 32'h0);
        bus_read(8'h02, r);
        check("R10 unaligned reads 0", r, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_output();
        t_preload();
        t_timing();
        t_input();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule